// File: doc/BRIEF.md
# Four-Bit Opcode-Driven Arithmetic and Shift Unit

This block is a purely combinational arithmetic/logic unit. It takes two operands `a` and `b`, a four-bit operation code `op` and a carry input. It returns a result word with three flags: carry-out, signed overflow and zero. The eight defined codes cover three kinds of work. The first is addition, with or without the incoming carry. The second is subtraction, which adds the two's complement of `b`. The third is left and right shifts, logical or arithmetic, by a variable amount that is the full unsigned value of `b`. Bitwise inversion of `a` completes the set.

Any code with the top bit set gives a zero result with both carry and overflow cleared. The block holds no state. A parent pipeline places it between its own registers, and all outputs settle from the current inputs alone.

Top module: `alu4_top`

## Requirements
- R1: Code 0111 gives res = (a + b) mod 16. cout is the carry out of bit 3. ovf is set when the signed sum lies outside -8..7.
- R2: Code 0110 gives res = (a + b + cin) mod 16. cout and ovf follow the same rules as R1, with cin included in the sum.
- R3: Code 0101 gives res = (a - b) mod 16. cout is 1 exactly when a >= b as unsigned values. ovf is set when the signed difference lies outside -8..7.
- R4: Code 0100 shifts a right by b and fills with zeros. Any b of 4 or more gives 0000.
- R5: Code 0011 shifts a right by b and fills with copies of a[3]. Any b of 4 or more gives four copies of a[3].
- R6: Codes 0010 and 0001 both shift a left by b and fill with zeros. Any b of 4 or more gives 0000.
- R7: For the shift codes, cout is the last bit dropped when the word is shifted one place at a time, b times. It is 0 when b is 0. Past the word width the dropped bit is 0, except for code 0011, where it is a[3].
- R8: For code 0001, ovf is set when a bit dropped during the shift, or the resulting bit 3, differs from the original a[3]. This is the same as the signed value a*2^b lying outside -8..7.
- R9: Code 0000 gives res = ~a with cout = 0 and ovf = 0.
- R10: ovf is 0 for codes 0000, 0010, 0011, 0100 and 1000-1111.
- R11: Codes 1000 through 1111 give res = 0000, cout = 0, ovf = 0 and zero = 1.
- R12: zero is 1 exactly when res is 0000, for every code.
- R13: cin has no effect on any output except under code 0110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand; the value that is shifted or inverted |
| b | input | 4 | Second operand; the addend, the subtrahend or the shift amount |
| op | input | 4 | Operation code |
| cin | input | 1 | Carry input, used only by code 0110 |
| res | output | 4 | Result word |
| cout | output | 1 | Carry-out, no-borrow flag or last bit shifted out |
| ovf | output | 1 | Signed overflow flag |
| zero | output | 1 | Set when res is all zeros |

## Verification
The bench sweeps every code, every operand pair and both carry values against a reference that uses integer arithmetic rather than a bit-level shifter. Several specific faults are targeted, and each shows up differently:

- Shift amounts of 4 to 15: an amount taken modulo the width would return a nonzero word, or the wrong carry, where 0000 or a sign fill is due.
- A shift by zero: it would leak a stale carry.
- Subtraction of 1000 and sums that cross from 0111 to 1000: an overflow test built on the wrong operand signs would miss these.
- An arithmetic left shift that only checks the final sign bit: it would miss overflow when a 1 has passed through bit 3 and left.
- A carry input that reaches non-ADC codes: it would shift every sum by one.
- An undefined code that falls through to an arithmetic path: it would yield a nonzero result.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_INV = 4'b0000;
  localparam logic [OPW-1:0] OP_ASL = 4'b0001;
  localparam logic [OPW-1:0] OP_LSL = 4'b0010;
  localparam logic [OPW-1:0] OP_ASR = 4'b0011;
  localparam logic [OPW-1:0] OP_LSR = 4'b0100;
  localparam logic [OPW-1:0] OP_SUB = 4'b0101;
  localparam logic [OPW-1:0] OP_ADC = 4'b0110;
  localparam logic [OPW-1:0] OP_ADD = 4'b0111;

  typedef enum logic [1:0] {
    SH_LEFT_LOG   = 2'd0,
    SH_LEFT_ARI   = 2'd1,
    SH_RIGHT_LOG  = 2'd2,
    SH_RIGHT_ARI  = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/alu4_addsub.sv
`timescale 1ns/1ps
module alu4_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         do_sub,
  input  logic         use_cin,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   c;

  assign b_eff = do_sub ? ~b : b;
  assign c[0]  = do_sub | (use_cin & cin);

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p      = a[i] ^ b_eff[i];
    assign sum[i] = p ^ c[i];
    assign c[i+1] = (a[i] & b_eff[i]) | (p & c[i]);
  end

  assign carry = c[W];
  // signed overflow: carry into the sign bit differs from carry out of it
  assign ovf   = c[W] ^ c[W-1];
endmodule

// File: rtl/alu4_shift.sv
`timescale 1ns/1ps
module alu4_shift
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] amt,
  input  shift_kind_e  kind,
  output logic [W-1:0] res,
  output logic         last_out,
  output logic         ovf
);
  localparam int MAXSTEP = W + 1;

  typedef struct packed {
    logic [W-1:0] v;
    logic         co;
    logic         ov;
  } sh_t;

  // One-place-at-a-time shift; steps beyond W+1 repeat step W+1 exactly.
  function automatic sh_t do_shift(input logic [W-1:0] x,
                                   input logic [W-1:0] n,
                                   input shift_kind_e  k);
    sh_t          r;
    logic [W-1:0] cur;
    logic         drop;
    logic         sgn;
    int           steps;
    cur   = x;
    sgn   = x[W-1];
    drop  = 1'b0;
    r     = '0;
    steps = (32'(n) > 32'(W)) ? MAXSTEP : int'(32'(n));
    for (int s = 1; s <= MAXSTEP; s++) begin
      if (s <= steps) begin
        case (k)
          SH_LEFT_LOG, SH_LEFT_ARI: begin
            drop = cur[W-1];
            cur  = {cur[W-2:0], 1'b0};
          end
          SH_RIGHT_LOG: begin
            drop = cur[0];
            cur  = {1'b0, cur[W-1:1]};
          end
          default: begin
            drop = cur[0];
            cur  = {cur[W-1], cur[W-1:1]};
          end
        endcase
        r.co = drop;
        if (drop != sgn) r.ov = 1'b1;
      end
    end
    if (cur[W-1] != sgn) r.ov = 1'b1;
    if (k != SH_LEFT_ARI) r.ov = 1'b0;
    r.v = cur;
    return r;
  endfunction

  sh_t out_s;
  assign out_s    = do_shift(a, amt, kind);
  assign res      = out_s.v;
  assign last_out = out_s.co;
  assign ovf      = out_s.ov;
endmodule

// File: rtl/alu4_top.sv
`timescale 1ns/1ps
module alu4_top
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [OPW-1:0] op,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           ovf,
  output logic           zero
);
  // named internal events, visible to the bound checker
  logic         sel_sub;
  logic         sel_cin;
  logic         sel_arith;
  logic         sel_shift;
  shift_kind_e  sh_kind;
  logic [W-1:0] add_sum;
  logic         add_co;
  logic         add_ov;
  logic [W-1:0] sh_res;
  logic         sh_co;
  logic         sh_ov;

  always_comb begin
    sel_sub   = (op == OP_SUB);
    sel_cin   = (op == OP_ADC);
    sel_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
    sel_shift = (op == OP_ASL) || (op == OP_LSL) || (op == OP_ASR) || (op == OP_LSR);
    case (op)
      OP_ASL:  sh_kind = SH_LEFT_ARI;
      OP_ASR:  sh_kind = SH_RIGHT_ARI;
      OP_LSR:  sh_kind = SH_RIGHT_LOG;
      default: sh_kind = SH_LEFT_LOG;
    endcase
  end

  alu4_addsub #(.W(W)) u_addsub (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .do_sub  (sel_sub),
    .use_cin (sel_cin),
    .sum     (add_sum),
    .carry   (add_co),
    .ovf     (add_ov)
  );

  alu4_shift #(.W(W)) u_shift (
    .a        (a),
    .amt      (b),
    .kind     (sh_kind),
    .res      (sh_res),
    .last_out (sh_co),
    .ovf      (sh_ov)
  );

  always_comb begin
    res  = '0;
    cout = 1'b0;
    ovf  = 1'b0;
    if (sel_arith) begin
      res  = add_sum;
      cout = add_co;
      ovf  = add_ov;
    end else if (sel_shift) begin
      res  = sh_res;
      cout = sh_co;
      ovf  = sh_ov;
    end else if (op == OP_INV) begin
      res  = ~a;
    end
  end

  assign zero = ~|res;
endmodule

// File: rtl/alu4_chk.sv
`timescale 1ns/1ps
module alu4_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic         cin,
  input logic [W-1:0] res,
  input logic         cout,
  input logic         ovf,
  input logic         zero,
  input logic         sh_co,
  input logic         add_ov
);
  always_comb begin
    if (op == 4'b0111)
      p_add_sum_r1: assert ({cout, res} == ({1'b0, a} + {1'b0, b}));
    if (op == 4'b0110)
      p_adc_sum_r2: assert ({cout, res} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)));
    if (op == 4'b0101)
      p_sub_diff_r3: assert ((res == W'(a - b)) && (cout == (a >= b)));
    if (op == 4'b0100)
      p_lsr_r4: assert (res == (a >> b));
    if (op == 4'b0011)
      p_asr_r5: assert (res == W'($signed(a) >>> b));
    if (op == 4'b0010 || op == 4'b0001)
      p_left_r6: assert (res == (a << b));
    if ((op == 4'b0010 || op == 4'b0100) && b == '0)
      p_noshift_carry_r7: assert (!cout && !sh_co);
    if (op == 4'b0000)
      p_invert_r9: assert ((res == ~a) && !cout && !ovf);
    if (op == 4'b0000 || op == 4'b0010 || op == 4'b0011 || op == 4'b0100 || op[3])
      p_no_overflow_r10: assert (!ovf);
    if (op[3])
      p_undef_code_r11: assert ((res == '0) && !cout && !ovf && zero);
    if (op == 4'b0111 && (a[W-1] != b[W-1]))
      p_mixed_sign_add_r1: assert (!add_ov);
    p_zero_flag_r12: assert (zero == ($countones(res) == 0));
  end
endmodule

bind alu4_top alu4_chk #(.W(W)) u_chk (
  .a      (a),
  .b      (b),
  .op     (op),
  .cin    (cin),
  .res    (res),
  .cout   (cout),
  .ovf    (ovf),
  .zero   (zero),
  .sh_co  (sh_co),
  .add_ov (add_ov)
);

// File: tb/alu4_top_tb_top.sv
`timescale 1ns/1ps
module alu4_top_tb_top;
  logic       clk = 1'b0;
  logic [3:0] a, b, op;
  logic       cin;
  logic [3:0] res;
  logic       cout, ovf, zero;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu4_top #(.W(4)) dut_i (
    .a(a), .b(b), .op(op), .cin(cin),
    .res(res), .cout(cout), .ovf(ovf), .zero(zero)
  );

  // {op, a, b, cin, res, cout, ovf, zero}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0111, 4'b0011, 4'b0100, 1'b0, 4'b0111, 1'b0, 1'b0, 1'b0}, // R1 plain add
    {4'b0111, 4'b0111, 4'b0001, 1'b0, 4'b1000, 1'b0, 1'b1, 1'b0}, // R1 overflow
    {4'b0111, 4'b1111, 4'b0001, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1}, // R1 carry, R12
    {4'b0110, 4'b0111, 4'b0000, 1'b1, 4'b1000, 1'b0, 1'b1, 1'b0}, // R2 carry-in
    {4'b0111, 4'b0010, 4'b0010, 1'b1, 4'b0100, 1'b0, 1'b0, 1'b0}, // R13 cin ignored
    {4'b0101, 4'b0011, 4'b0011, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1}, // R3 equal
    {4'b0101, 4'b0010, 4'b0011, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0}, // R3 borrow
    {4'b0101, 4'b1000, 4'b0001, 1'b0, 4'b0111, 1'b1, 1'b1, 1'b0}, // R3 overflow
    {4'b0100, 4'b1011, 4'b0010, 1'b0, 4'b0010, 1'b1, 1'b0, 1'b0}, // R4 R7
    {4'b0011, 4'b1000, 4'b0101, 1'b0, 4'b1111, 1'b1, 1'b0, 1'b0}, // R5 R7 past width
    {4'b0010, 4'b1011, 4'b0100, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1}, // R6 R7 full width
    {4'b0001, 4'b0011, 4'b0001, 1'b0, 4'b0110, 1'b0, 1'b0, 1'b0}, // R8 no overflow
    {4'b0001, 4'b0101, 4'b0001, 1'b0, 4'b1010, 1'b0, 1'b1, 1'b0}, // R8 sign flip
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1}, // R9
    {4'b1010, 4'b0111, 4'b0101, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1}, // R11
    {4'b0100, 4'b1001, 4'b0000, 1'b0, 4'b1001, 1'b0, 1'b0, 1'b0}  // R7 zero amount
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0111: return "R1";
      4'b0110: return "R2";
      4'b0101: return "R3";
      4'b0100: return "R4";
      4'b0011: return "R5";
      4'b0010: return "R6";
      4'b0001: return "R8";
      4'b0000: return "R9";
      default: return "R11";
    endcase
  endfunction

  // integer reference model: returns {res, cout, ovf, zero}
  function automatic logic [6:0] ref_model(input logic [3:0] o, input logic [3:0] x,
                                           input logic [3:0] y, input logic c);
    int ua, ub, sa, sb, t, s;
    logic [3:0] r;
    logic co, of;
    ua = int'(x); ub = int'(y);
    sa = x[3] ? ua - 16 : ua;
    sb = y[3] ? ub - 16 : ub;
    r = 4'b0; co = 1'b0; of = 1'b0;
    case (o)
      4'b0111, 4'b0110: begin
        t  = ua + ub + ((o == 4'b0110) ? int'(c) : 0);
        r  = t[3:0]; co = t[4];
        s  = sa + sb + ((o == 4'b0110) ? int'(c) : 0);
        of = (s > 7) || (s < -8);
      end
      4'b0101: begin
        t  = ua - ub;
        r  = t[3:0]; co = (ua >= ub);
        s  = sa - sb;
        of = (s > 7) || (s < -8);
      end
      4'b0100: begin
        t  = (ua << 16) >> ub;
        r  = t[19:16]; co = (ub == 0) ? 1'b0 : t[15];
      end
      4'b0011: begin
        t  = (sa * 65536) >>> ub;
        r  = t[19:16]; co = (ub == 0) ? 1'b0 : t[15];
      end
      4'b0010, 4'b0001: begin
        t  = ua << ub;
        r  = t[3:0]; co = (ub == 0) ? 1'b0 : t[4];
        if (o == 4'b0001) begin
          s  = sa * (1 << ub);
          of = (s > 7) || (s < -8);
        end
      end
      4'b0000: r = ~x;
      default: ;
    endcase
    return {r, co, of, (r == 4'b0)};
  endfunction

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%b b=%b cin=%b got{res,co,of,z}=%b expected=%b",
               tag, op, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [3:0] x,
                       input logic [3:0] y, input logic c);
    @(posedge clk);
    #1;
    op = o; a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  initial begin
    op = 4'b1111; a = '0; b = '0; cin = 1'b0;
    // idle state: an undefined code drives the quiet result (R11, R12)
    @(negedge clk);
    check("R11 idle", {res, cout, ovf, zero}, 7'b0000_001);

    // directed table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][19:16], VEC[i][15:12], VEC[i][11:8], VEC[i][7]);
      check({tag_of(VEC[i][19:16]), " table"}, {res, cout, ovf, zero}, VEC[i][6:0]);
    end

    // exhaustive sweep: R7 carry, R10 overflow, R12 zero, R13 cin isolation
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            apply(4'(o), 4'(x), 4'(y), 1'(c));
            check({tag_of(4'(o)), " sweep R7 R10 R12 R13"}, {res, cout, ovf, zero},
                  ref_model(4'(o), 4'(x), 4'(y), 1'(c)));
          end

    // R13: toggling cin under a sum that would carry must not move the result
    apply(4'b0111, 4'b1111, 4'b0000, 1'b1);
    check("R13 cin high", {res, cout, ovf, zero}, 7'b1111_000);
    apply(4'b0111, 4'b1111, 4'b0000, 1'b0);
    check("R13 cin low", {res, cout, ovf, zero}, 7'b1111_000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: got=hung expected=complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule